// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block merges the interrupt events of several ports into one host interrupt, using two levels of status. Each port has an event status register and an enable register. Every event input sets its status bit. The enabled status bits of a port are ORed into a level for that port. A global status register holds one bit per port. A port's level sets that bit, and the bit is held as a level-triggered latch. Software clears a status bit by writing a one to it over a simple single-cycle register bus. The right order is to clear the port's event first and then the matching global bit. A global bit cleared while its port's level is still high stays set.

The host sees two things. One is a level interrupt, which is the OR of the global bits gated by a global enable. The other is a single-cycle message pulse. The pulse is sent when the global register goes from empty to non-empty. It is also sent after any global clear that leaves a bit pending, so that events still waiting after a partial clear are not lost. A parameter marks which ports are implemented. Global bits of unimplemented ports never set.

Top module: `irq_aggregator`

## Requirements
- R1: A high event input sets its port status bit at the next clock edge. Writing a one to a status bit clears it. An event in the same cycle as a clear of that bit wins, and the bit stays set.
- R2: A port's level is high while any status bit that is also enabled in that port's enable register is set. Masked events are still recorded in the status register but do not reach the global register.
- R3: A global status bit is set at the clock edge after its port's level is high, but only for ports marked in IMPL_MASK. Global bits of unimplemented ports never set.
- R4: Writing a one to a global bit while that port's level is high leaves the bit set. The same write clears the bit once the port's level is low.
- R5: A write of all ones to the global status register clears every global bit whose port level is low.
- R6: irqLevel is high exactly when the global enable (bit 0 of the control register) is set and at least one global bit is set.
- R7: msiPulse is high for one cycle, in the first cycle in which the global register is non-empty after being empty. It is only sent while the global enable is set.
- R8: A write to the global status register that clears at least one pending bit sends msiPulse in the following cycle if any global bit is still set afterwards and the global enable is set.
- R9: After reset, all status, enable, global and control bits are zero, irqLevel is low and msiPulse is low.
- R10: The register map is as follows. Port p status is at address 2p and port p enable is at 2p+1. The global status register is at 2·NPORTS, with bit p standing for port p. The control register is at 2·NPORTS+1, with bit 0 as the global enable. busRdData shows the addressed register combinationally, zero-extended. Unmapped addresses read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evIn | input | NPORTS*NEV | Event inputs; bits [p*NEV +: NEV] belong to port p |
| busWrEn | input | 1 | Register write strobe, one write per cycle |
| busAddr | input | ADDR_W | Register address for reads and writes |
| busWrData | input | DATA_W | Write data; ones clear bits in status registers |
| busRdData | output | DATA_W | Read data of the addressed register |
| irqLevel | output | 1 | Level interrupt to the host |
| msiPulse | output | 1 | Single-cycle interrupt message request |

## Verification
A wrong port status or enable bit shows up on busRdData as soon as that register is addressed. It also reaches the global status register and irqLevel two edges after the event. A global latch that drops while its port's level is high, or that fails to clear once the level is low, changes both the global status read-back and irqLevel in the cycle after the write. A message pulse that is missing, duplicated or sent while disabled differs from the reference on msiPulse in that same cycle. This is why the bench compares all three outputs on every clock against a behavioural model, under both directed and random event and clear traffic.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Write strobes from the decoder to the register datapath
  typedef struct packed {
    logic statClr;   // write-one-to-clear into a port status register
    logic enWr;      // load a port enable register
    logic globClr;   // write-one-to-clear into the global status register
    logic ctlWr;     // load the control register
  } regStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STAT,
    RD_EN,
    RD_GLOB,
    RD_CTL
  } rdSel_e;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe,
  output rdSel_e            rdSel,
  output logic [IDX_W-1:0]  portIdx
);

  localparam logic [ADDR_W-1:0] GSTAT = ADDR_W'(2 * NPORTS);
  localparam logic [ADDR_W-1:0] GCTL  = ADDR_W'(2 * NPORTS + 1);

  always_comb begin
    strobe  = '0;
    rdSel   = RD_NONE;
    portIdx = busAddr[IDX_W:1];
    if (busAddr < GSTAT) begin
      rdSel = busAddr[0] ? RD_EN : RD_STAT;
    end else if (busAddr == GSTAT) begin
      rdSel = RD_GLOB;
    end else if (busAddr == GCTL) begin
      rdSel = RD_CTL;
    end
    if (busWrEn) begin
      unique case (rdSel)
        RD_STAT: strobe.statClr = 1'b1;
        RD_EN:   strobe.enWr    = 1'b1;
        RD_GLOB: strobe.globClr = 1'b1;
        RD_CTL:  strobe.ctlWr   = 1'b1;
        default: ;
      endcase
    end
  end

  // R10: a write reaches at most one register
  always_comb begin
    a_r10_one_strobe: assert ($onehot0(strobe));
  end

endmodule

// File: rtl/irq_agg_port.sv
module irq_agg_port #(
  parameter int NEV = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NEV-1:0] evIn,
  input  logic           statClr,
  input  logic           enWr,
  input  logic [NEV-1:0] wrData,
  output logic [NEV-1:0] stat,
  output logic [NEV-1:0] en,
  output logic           level
);

  logic [NEV-1:0] clrMask;

  assign clrMask = statClr ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat <= '0;
      en   <= '0;
    end else begin
      // events are ORed in after the clear, so an event wins over a clear
      stat <= (stat & ~clrMask) | evIn;
      if (enWr) en <= wrData;
    end
  end

  assign level = |(stat & en);

  for (genvar i = 0; i < NEV; i++) begin : g_chk
    a_r1_event_sets: assert property (@(posedge clk) disable iff (!rstN)
      evIn[i] |=> stat[i]);
    a_r1_clear_works: assert property (@(posedge clk) disable iff (!rstN)
      (statClr && wrData[i] && !evIn[i]) |=> !stat[i]);
  end

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int                NPORTS    = 4,
  parameter int                NEV       = 8,
  parameter int                DATA_W    = 8,
  parameter int                IDX_W     = 2,
  parameter logic [NPORTS-1:0] IMPL_MASK = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NPORTS*NEV-1:0] evIn,
  input  regStrobe_t            strobe,
  input  rdSel_e                rdSel,
  input  logic [IDX_W-1:0]      portIdx,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic                  irqLevel,
  output logic                  msiPulse
);

  logic [NEV-1:0]    statArr [NPORTS];
  logic [NEV-1:0]    enArr   [NPORTS];
  logic [NPORTS-1:0] portLevel;
  logic [NPORTS-1:0] glob, globNext, globClrMask;
  logic              gen, clearHit, msiNext;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    irq_agg_port #(.NEV(NEV)) u_port (
      .clk     (clk),
      .rstN    (rstN),
      .evIn    (evIn[p*NEV +: NEV]),
      .statClr (strobe.statClr && (portIdx == IDX_W'(p))),
      .enWr    (strobe.enWr && (portIdx == IDX_W'(p))),
      .wrData  (wrData[NEV-1:0]),
      .stat    (statArr[p]),
      .en      (enArr[p]),
      .level   (portLevel[p])
    );
  end

  assign globClrMask = strobe.globClr ? wrData[NPORTS-1:0] : '0;
  // a high port level re-sets its global bit over any clear
  assign globNext    = (glob & ~globClrMask) | (portLevel & IMPL_MASK);
  assign clearHit    = |(glob & globClrMask);
  assign msiNext     = gen && (|globNext) && (!(|glob) || clearHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glob     <= '0;
      gen      <= 1'b0;
      msiPulse <= 1'b0;
    end else begin
      glob     <= globNext;
      msiPulse <= msiNext;
      if (strobe.ctlWr) gen <= wrData[0];
    end
  end

  assign irqLevel = gen && (|glob);

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      RD_STAT: rdData[NEV-1:0]    = statArr[portIdx];
      RD_EN:   rdData[NEV-1:0]    = enArr[portIdx];
      RD_GLOB: rdData[NPORTS-1:0] = glob;
      RD_CTL:  rdData[0]          = gen;
      default: ;
    endcase
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    if (IMPL_MASK[p]) begin : g_impl
      a_r3_level_sets: assert property (@(posedge clk) disable iff (!rstN)
        portLevel[p] |=> glob[p]);
    end else begin : g_unimpl
      a_r3_unimpl_quiet: assert property (@(posedge clk) disable iff (!rstN)
        !glob[p]);
    end
    a_r5_clear_low: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.globClr && wrData[p] && !portLevel[p]) |=> !glob[p]);
  end

  a_r7_msi_pending: assert property (@(posedge clk) disable iff (!rstN)
    msiPulse |-> (|glob));
  a_r7_msi_enabled: assert property (@(posedge clk) disable iff (!rstN)
    msiPulse |-> $past(gen));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int                NPORTS    = 4,
  parameter int                NEV       = 8,
  parameter logic [NPORTS-1:0] IMPL_MASK = 4'b1011,
  localparam int               ADDR_W    = $clog2(2 * NPORTS + 2),
  localparam int               DATA_W    = (NEV > NPORTS) ? NEV : NPORTS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NPORTS*NEV-1:0] evIn,
  input  logic                  busWrEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  output logic                  irqLevel,
  output logic                  msiPulse
);

  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  regStrobe_t       strobe;
  rdSel_e           rdSel;
  logic [IDX_W-1:0] portIdx;

  irq_agg_ctrl #(
    .NPORTS (NPORTS),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .portIdx (portIdx)
  );

  irq_agg_datapath #(
    .NPORTS    (NPORTS),
    .NEV       (NEV),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .IMPL_MASK (IMPL_MASK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .evIn     (evIn),
    .strobe   (strobe),
    .rdSel    (rdSel),
    .portIdx  (portIdx),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .irqLevel (irqLevel),
    .msiPulse (msiPulse)
  );

  // R9: nothing is signalled right after reset is released
  a_r9_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> (!irqLevel && !msiPulse));

endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;

  localparam int NP = 4;
  localparam int NE = 8;
  localparam logic [3:0] IMPL = 4'b1011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evIn = '0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        irqLevel, msiPulse;

  int checks = 0;
  int fails = 0;
  int msiCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.NPORTS(NP), .NEV(NE), .IMPL_MASK(IMPL)) u_dut (
    .clk(clk), .rstN(rstN), .evIn(evIn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqLevel(irqLevel), .msiPulse(msiPulse)
  );

  // behavioural reference model
  logic [7:0] mStat [NP];
  logic [7:0] mEn   [NP];
  logic [3:0] mGlob;
  logic       mGen, mMsi;

  always @(posedge clk) begin
    logic [3:0] lvl, g;
    logic [7:0] s;
    logic       hit;
    if (!rstN) begin
      for (int p = 0; p < NP; p++) begin mStat[p] = '0; mEn[p] = '0; end
      mGlob = '0; mGen = 0; mMsi = 0;
    end else begin
      for (int p = 0; p < NP; p++) lvl[p] = ((mStat[p] & mEn[p]) != 0);
      hit = busWrEn && busAddr == 4'd8 && ((mGlob & busWrData[3:0]) != 0);
      g = mGlob;
      if (busWrEn && busAddr == 4'd8) g = g & ~busWrData[3:0];
      for (int p = 0; p < NP; p++) if (lvl[p] && IMPL[p]) g[p] = 1'b1;
      mMsi = mGen && (g != 0) && (mGlob == 0 || hit);
      for (int p = 0; p < NP; p++) begin
        s = mStat[p];
        if (busWrEn && busAddr == 4'(2*p)) s = s & ~busWrData;
        mStat[p] = s | evIn[p*NE +: NE];
        if (busWrEn && busAddr == 4'(2*p+1)) mEn[p] = busWrData;
      end
      if (busWrEn && busAddr == 4'd9) mGen = busWrData[0];
      mGlob = g;
    end
  end

  function automatic logic [7:0] modelRd(input logic [3:0] a);
    if (a < 4'd8) return a[0] ? mEn[a >> 1] : mStat[a >> 1];
    if (a == 4'd8) return {4'b0, mGlob};
    if (a == 4'd9) return {7'b0, mGen};
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R6 irqLevel", {7'b0, irqLevel}, {7'b0, mGen && (mGlob != 0)});
      check("R7/R8 msiPulse", {7'b0, msiPulse}, {7'b0, mMsi});
      check("R10 busRdData", busRdData, modelRd(busAddr));
      if (msiPulse) msiCnt++;
    end
  end

  task automatic step(input logic [31:0] e, input logic w, input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    evIn = e; busWrEn = w; busAddr = a; busWrData = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 0, 4'd0, 8'h00);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step('0, 1, a, d);
    idle(1);
  endtask

  task automatic ev(input logic [31:0] e);
    step(e, 0, 4'd0, 8'h00);
    idle(2);
  endtask

  task automatic expectRd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    step('0, 0, a, 8'h00);
    @(negedge clk); #0.1;
    check(tag, busRdData, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    // R9 reset state
    expectRd(4'd8, 8'h00, "R9 global after reset");
    expectRd(4'd1, 8'h00, "R9 enable after reset");
    check("R9 irqLevel", {7'b0, irqLevel}, 8'h00);
    check("R9 msiPulse", {7'b0, msiPulse}, 8'h00);

    wr(4'd9, 8'h01);
    expectRd(4'd9, 8'h01, "R10 control read");
    wr(4'd1, 8'h08);
    ev(32'h0000_0008);
    expectRd(4'd0, 8'h08, "R1 event sets status");
    expectRd(4'd8, 8'h01, "R3 level sets global");
    check("R6 irq high", {7'b0, irqLevel}, 8'h01);

    // R2 masked event recorded, not propagated
    ev(32'h0000_0100);
    expectRd(4'd2, 8'h01, "R2 masked status recorded");
    expectRd(4'd8, 8'h01, "R2 masked event kept from global");

    // R4 clear while level high
    wr(4'd8, 8'h01);
    expectRd(4'd8, 8'h01, "R4 global stays while level high");

    // R3 unimplemented port 2
    wr(4'd5, 8'h01);
    ev(32'h0001_0000);
    expectRd(4'd4, 8'h01, "R1 port2 status set");
    expectRd(4'd8, 8'h01, "R3 unimplemented port never sets");

    // R1 event wins over same-cycle clear
    step(32'h0000_0008, 1, 4'd0, 8'h08);
    idle(1);
    expectRd(4'd0, 8'h08, "R1 event beats clear");

    // R4 correct clear order
    wr(4'd0, 8'h08);
    expectRd(4'd0, 8'h00, "R1 status cleared");
    expectRd(4'd8, 8'h01, "R4 global held until cleared");
    wr(4'd8, 8'h01);
    expectRd(4'd8, 8'h00, "R4 global clears when level low");
    check("R6 irq low", {7'b0, irqLevel}, 8'h00);

    // R5 all-ones clear
    wr(4'd4, 8'h01);
    wr(4'd3, 8'h01);
    wr(4'd7, 8'h80);
    ev(32'h8000_0000);
    expectRd(4'd8, 8'h0A, "R3 two ports pending");
    wr(4'd2, 8'h01);
    wr(4'd6, 8'h80);
    wr(4'd8, 8'hFF);
    expectRd(4'd8, 8'h00, "R5 all-ones clears low-level bits");

    // R8 partial clear sends a new message
    ev(32'h0000_0008);
    ev(32'h0000_0100);
    idle(2);
    wr(4'd0, 8'h08);
    idle(2);
    c0 = msiCnt;
    wr(4'd8, 8'h01);
    idle(3);
    check("R8 message after partial clear", 8'(msiCnt - c0), 8'h01);
    expectRd(4'd8, 8'h02, "R8 remaining bit pending");
    wr(4'd2, 8'h01);
    wr(4'd8, 8'hFF);
    idle(2);

    // R7 no message while globally disabled
    wr(4'd9, 8'h00);
    c0 = msiCnt;
    ev(32'h0000_0008);
    idle(3);
    check("R7 no message when disabled", 8'(msiCnt - c0), 8'h00);
    check("R6 irq gated by enable", {7'b0, irqLevel}, 8'h00);
    expectRd(4'd8, 8'h01, "R7 global still latched");
    wr(4'd0, 8'h08);
    wr(4'd8, 8'hFF);
    wr(4'd9, 8'h01);

    // random traffic, checked each cycle by the model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] e;
      logic [3:0]  a;
      e = ($urandom_range(0, 7) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'h0;
      a = 4'($urandom_range(0, 11));
      if ($urandom_range(0, 3) == 0)
        step(e, 1, a, (a == 4'd8 && $urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom));
      else
        step(e, 0, a, 8'h00);
    end
    idle(2);
    done = 1;
    summary();
    $finish;
  end

endmodule